// File: doc/BRIEF.md
# BCD Calendar Counter with Atomic Commit

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year. The year counts 00..99, which stands for 1970..2069. The counters advance by one second on each single-cycle `tick` pulse. That pulse comes from a divider outside the block. The block does not compute leap years. Software supplies a leap flag along with the year, and February ends on day 29 or day 28 according to that flag.

Software reaches the block through a small 16-bit register port. Writes to the time registers do not touch the running clock. They fill a staging copy. Setting the trigger bit in the update register then copies every staged field, and the leap flag, into the running counters in one clock edge. A software read never sees a partly loaded date. A control bit selects 24-hour counting or 12-hour counting with a PM flag.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the running time reads as 00:00:00, weekday 0, day 01, month 01, year 00, with the leap flag clear. The control register reads 0x0001 (24-hour mode) and the update register reads 0x0000.
- R2: Writes to the time registers go only to the staging copy, so the running value read back at those addresses does not change. The field keeps only its own width: seconds and minutes 7 bits, hours 6, weekday 3, day 6, month 5, year 8. Read data always has all unused bits zero, except bit 15 of the year register, which is the leap flag.
- R3: Register addresses are: 0x0 control (bit 0 = 24-hour mode), 0x1 seconds, 0x2 minutes, 0x3 hours, 0x4 weekday, 0x5 day, 0x6 month, 0x7 year (bit 15 = leap flag), 0x8 update. Any other address reads 0. Writing the update register with bit 15 set loads all staged fields and the leap flag into the running counters on the second clock edge after the write is sampled. A write with bit 15 clear has no effect.
- R4: Bit 15 of the update register reads as 1 from the edge that samples the trigger write until the load edge, and as 0 afterwards.
- R5: A tick that arrives in the same cycle as the load is dropped. The counters take exactly the staged values.
- R6: Seconds and minutes count in BCD from 00 to 59. The step from 59 to 00 carries into the next field, and a step from x9 moves to the next tens digit.
- R7: In 24-hour mode, hours count from 00 to 23. The step from 23 to 00 advances the date.
- R8: In 12-hour mode (control bit 0 = 0), hour bits 4:0 hold BCD 01..12 and bit 5 is the PM flag. 11 goes to 12 and toggles PM. 12 goes to 01 with PM unchanged. The date advances only on the step from 11 PM to 12 AM.
- R9: The weekday advances at each date change and wraps from 6 to 0.
- R10: Months 04, 06, 09 and 11 end after day 30. Months 01, 03, 05, 07, 08, 10 and 12 end after day 31. Day then returns to 01 and the month advances.
- R11: February ends after day 29 when the leap flag is set, and after day 28 when it is clear.
- R12: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00, and the leap flag keeps its value.
- R13: In a cycle with neither a tick nor a load, the running time does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Combinational read data for `addr` |

## Verification
The bench loads dates that sit one second before each boundary. It then ticks once and reads every field, checking:
- the full New Year cascade from 23:59:59 on 31 December of year 99;
- the end of February with and without the leap flag, and the end of a 30-day month;
- the three 12-hour transitions.

A design that takes February's length from the month number alone would land on 29 February when the flag is clear, or skip 29 February when it is set. A design that clears the leap flag when the century wraps would show a year of 0x0000 instead of 0x8000. The bench also places a tick exactly on the load cycle: a design that lets the tick through reports seconds one higher than the staged value. It reads the trigger bit in the cycle after the write and again after the load, to catch a flag that never clears. It also reads the running seconds after a staged write, to catch writes that go straight to the running counters.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    localparam int REG_W      = 16;
    localparam int ADDR_W     = 4;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 7;
    localparam int LEAP_BIT   = 15;
    localparam int TRIG_BIT   = 15;

    // field slots inside the packed time vector
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_WDAY = 3;
    localparam int F_DAY  = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_FIELD0 = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_YEAR   = 4'h7;
    localparam logic [ADDR_W-1:0] ADR_UPD    = 4'h8;

    typedef struct packed {
        logic                                   leap;
        logic [NUM_FIELDS-1:0][FIELD_W-1:0]     f;
    } caltime_t;

    // year 00, month 01, day 01, everything else zero
    localparam caltime_t CAL_RESET = caltime_t'({1'b0, 56'h00_01_01_00_00_00_00});

    function automatic logic [FIELD_W-1:0] field_mask(input int idx);
        case (idx)
            F_SEC, F_MIN:  return 8'h7F;
            F_HOUR, F_DAY: return 8'h3F;
            F_WDAY:        return 8'h07;
            F_MON:         return 8'h1F;
            default:       return 8'hFF;
        endcase
    endfunction

    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        return v + 8'h01;
    endfunction

    function automatic logic [FIELD_W-1:0] month_last(input logic [FIELD_W-1:0] mon,
                                                      input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // returns {carry_to_date, next_hour[5:0]}
    function automatic logic [6:0] hour_step(input logic [5:0] hr, input logic mode24);
        logic [7:0] inc;
        if (mode24) begin
            if (hr == 6'h23)
                return {1'b1, 6'h00};
            inc = bcd_inc({2'b00, hr});
            return {1'b0, inc[5:0]};
        end
        if (hr[4:0] == 5'h11)
            return {hr[5], ~hr[5], 5'h12};
        if (hr[4:0] == 5'h12)
            return {1'b0, hr[5], 5'h01};
        inc = bcd_inc({3'b000, hr[4:0]});
        return {1'b0, hr[5], inc[4:0]};
    endfunction

endpackage

// File: rtl/bcdcal_regs.sv
module bcdcal_regs
    import bcdcal_pkg::*;
#(
    parameter logic RESET_MODE24 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output caltime_t          staged,
    output logic              mode24,
    output logic              pending
);

    logic [NUM_FIELDS-1:0][FIELD_W-1:0] stage_f;
    logic                               stage_leap;

    // untouched data bits of the write bus
    logic unused_wbits;
    assign unused_wbits = ^wdata[14:8];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_stage
        logic [FIELD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= CAL_RESET.f[g];
            else if (wr_en && addr == ADR_FIELD0 + ADDR_W'(g))
                q <= wdata[FIELD_W-1:0] & field_mask(g);
        end
        assign stage_f[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            stage_leap <= CAL_RESET.leap;
        else if (wr_en && addr == ADR_YEAR)
            stage_leap <= wdata[LEAP_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode24 <= RESET_MODE24;
        else if (wr_en && addr == ADR_CTRL)
            mode24 <= wdata[0];
    end

    // trigger flag lives for exactly one cycle: the load cycle
    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (pending)
            pending <= 1'b0;
        else if (wr_en && addr == ADR_UPD && wdata[TRIG_BIT])
            pending <= 1'b1;
    end

    assign staged = '{leap: stage_leap, f: stage_f};

endmodule

// File: rtl/bcdcal_engine.sv
module bcdcal_engine
    import bcdcal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     load,
    input  logic     mode24,
    input  caltime_t staged,
    output caltime_t now
);

    caltime_t   cur;
    caltime_t   nxt;
    logic       c_min;
    logic       c_hour;
    logic       c_day;
    logic       c_mon;
    logic       c_year;
    logic [6:0] hstep;

    always_comb begin
        nxt    = cur;
        c_min  = (cur.f[F_SEC] == 8'h59);
        c_hour = c_min && (cur.f[F_MIN] == 8'h59);
        hstep  = hour_step(cur.f[F_HOUR][5:0], mode24);
        c_day  = c_hour && hstep[6];
        c_mon  = c_day && (cur.f[F_DAY] == month_last(cur.f[F_MON], cur.leap));
        c_year = c_mon && (cur.f[F_MON] == 8'h12);

        nxt.f[F_SEC] = c_min ? 8'h00 : bcd_inc(cur.f[F_SEC]);

        if (c_min)
            nxt.f[F_MIN] = (cur.f[F_MIN] == 8'h59) ? 8'h00 : bcd_inc(cur.f[F_MIN]);

        if (c_hour)
            nxt.f[F_HOUR] = {2'b00, hstep[5:0]};

        if (c_day) begin
            nxt.f[F_WDAY] = (cur.f[F_WDAY] == 8'h06) ? 8'h00 : cur.f[F_WDAY] + 8'h01;
            nxt.f[F_DAY]  = c_mon ? 8'h01 : bcd_inc(cur.f[F_DAY]);
        end

        if (c_mon)
            nxt.f[F_MON] = c_year ? 8'h01 : bcd_inc(cur.f[F_MON]);

        if (c_year)
            nxt.f[F_YEAR] = (cur.f[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur.f[F_YEAR]);
    end

    // load wins over a coincident tick
    always_ff @(posedge clk) begin
        if (rst)
            cur <= CAL_RESET;
        else if (load)
            cur <= staged;
        else if (tick)
            cur <= nxt;
    end

    assign now = cur;

endmodule

// File: rtl/bcdcal_readback.sv
module bcdcal_readback
    import bcdcal_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  caltime_t          now,
    input  logic              mode24,
    input  logic              pending,
    output logic [REG_W-1:0]  rdata
);

    logic [ADDR_W-1:0] idx;

    always_comb begin
        idx   = addr - ADR_FIELD0;
        rdata = '0;
        if (addr == ADR_CTRL) begin
            rdata[0] = mode24;
        end else if (addr == ADR_UPD) begin
            rdata[TRIG_BIT] = pending;
        end else if (addr <= ADR_YEAR) begin
            for (int i = 0; i < NUM_FIELDS; i++)
                if (idx == ADDR_W'(i))
                    rdata[FIELD_W-1:0] = now.f[i] & field_mask(i);
            if (addr == ADR_YEAR)
                rdata[LEAP_BIT] = now.leap;
        end
    end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcdcal_pkg::*;
#(
    parameter logic RESET_MODE24 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata
);

    caltime_t shadow_q;
    caltime_t cur_time;
    logic     mode24;
    logic     upd_pending;

    bcdcal_regs #(
        .RESET_MODE24(RESET_MODE24)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .staged (shadow_q),
        .mode24 (mode24),
        .pending(upd_pending)
    );

    bcdcal_engine u_engine (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .load  (upd_pending),
        .mode24(mode24),
        .staged(shadow_q),
        .now   (cur_time)
    );

    bcdcal_readback u_rd (
        .addr   (addr),
        .now    (cur_time),
        .mode24 (mode24),
        .pending(upd_pending),
        .rdata  (rdata)
    );

endmodule

// File: rtl/bcdcal_checker.sv
module bcdcal_checker
    import bcdcal_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     tick,
    input logic     load,
    input caltime_t shadow,
    input caltime_t now
);

    p_load_copies_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> now == $past(shadow));

    p_trig_clears_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

    p_tick_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        (load && tick) |=> now.f[F_SEC] == $past(shadow.f[F_SEC]));

    p_sec_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && tick && now.f[F_SEC] == 8'h59) |=>
            (now.f[F_SEC] == 8'h00 && now.f[F_MIN] != $past(now.f[F_MIN])));

    p_leap_kept_r12: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(now.leap));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(now));

endmodule

bind bcd_calendar bcdcal_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .load  (upd_pending),
    .shadow(shadow_q),
    .now   (cur_time)
);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0]  a;
        logic [15:0] e;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    bcd_calendar dut (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata)
    );

    // monitor: pops expected items and compares away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                checks++;
                if (rdata !== it.e) begin
                    fails++;
                    $display("FAIL %s addr=%0h actual=%04h expected=%04h",
                             it.tag, it.a, rdata, it.e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        addr = a;
        it.a = a; it.e = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic tick1();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic commit();
        wr(4'h8, 16'h8000);
        @(posedge clk);
        #1;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y, input logic lp);
        wr(4'h1, {8'h00, s});
        wr(4'h2, {8'h00, m});
        wr(4'h3, {8'h00, h});
        wr(4'h4, {8'h00, w});
        wr(4'h5, {8'h00, d});
        wr(4'h6, {8'h00, mo});
        wr(4'h7, {lp, 7'h00, y});
        commit();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_rd(4'h1, 16'h0000, "R1 sec");
        expect_rd(4'h3, 16'h0000, "R1 hour");
        expect_rd(4'h4, 16'h0000, "R1 wday");
        expect_rd(4'h5, 16'h0001, "R1 day");
        expect_rd(4'h6, 16'h0001, "R1 mon");
        expect_rd(4'h7, 16'h0000, "R1 year");
        expect_rd(4'h0, 16'h0001, "R1 ctrl");
        expect_rd(4'h8, 16'h0000, "R1 upd");

        // R2 staging isolation and masking
        wr(4'h1, 16'h0045);
        wr(4'h2, 16'hFF25);
        expect_rd(4'h1, 16'h0000, "R2 staged not live");
        wr(4'h8, 16'h7FFF);
        @(posedge clk); #1;
        expect_rd(4'h1, 16'h0000, "R3 trigger bit clear ignored");
        expect_rd(4'hA, 16'h0000, "R3 unmapped addr");

        // R3/R4 commit and trigger readback
        wr(4'h8, 16'h8000);
        expect_rd(4'h8, 16'h8000, "R4 trigger pending");
        expect_rd(4'h8, 16'h0000, "R4 trigger cleared");
        expect_rd(4'h1, 16'h0045, "R3 sec loaded");
        expect_rd(4'h2, 16'h0025, "R2 min masked");

        // R6 seconds counting
        tick1();
        expect_rd(4'h1, 16'h0046, "R6 sec step");
        set_time(8'h09, 8'h10, 8'h05, 8'h02, 8'h10, 8'h03, 8'h20, 1'b0);
        tick1();
        expect_rd(4'h1, 16'h0010, "R6 bcd tens");
        set_time(8'h59, 8'h59, 8'h10, 8'h02, 8'h10, 8'h03, 8'h20, 1'b0);
        tick1();
        expect_rd(4'h2, 16'h0000, "R6 min wrap");
        expect_rd(4'h3, 16'h0011, "R7 hour step");

        // R13 idle hold
        repeat (5) @(posedge clk);
        expect_rd(4'h1, 16'h0000, "R13 idle sec");
        expect_rd(4'h3, 16'h0011, "R13 idle hour");

        // R7 R9 R12 new year cascade
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 1'b1);
        tick1();
        expect_rd(4'h1, 16'h0000, "R6 cascade sec");
        expect_rd(4'h3, 16'h0000, "R7 hour wrap");
        expect_rd(4'h4, 16'h0000, "R9 wday wrap");
        expect_rd(4'h5, 16'h0001, "R10 day wrap");
        expect_rd(4'h6, 16'h0001, "R12 month wrap");
        expect_rd(4'h7, 16'h8000, "R12 year wrap leap kept");

        // R11 february
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h01, 1'b0);
        tick1();
        expect_rd(4'h5, 16'h0001, "R11 feb28 no leap day");
        expect_rd(4'h6, 16'h0003, "R11 feb28 no leap mon");
        expect_rd(4'h4, 16'h0002, "R9 wday step");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h02, 1'b1);
        tick1();
        expect_rd(4'h5, 16'h0029, "R11 feb28 leap day");
        expect_rd(4'h6, 16'h0002, "R11 feb28 leap mon");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h02, 1'b1);
        tick1();
        expect_rd(4'h5, 16'h0001, "R11 feb29 leap day");
        expect_rd(4'h6, 16'h0003, "R11 feb29 leap mon");

        // R10 month lengths
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10, 1'b0);
        tick1();
        expect_rd(4'h5, 16'h0001, "R10 apr30 day");
        expect_rd(4'h6, 16'h0005, "R10 apr30 mon");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h10, 1'b0);
        tick1();
        expect_rd(4'h5, 16'h0031, "R10 jan30 day");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h11, 8'h10, 1'b0);
        tick1();
        expect_rd(4'h6, 16'h0012, "R10 nov30 mon");

        // R8 12-hour mode
        wr(4'h0, 16'h0000);
        expect_rd(4'h0, 16'h0000, "R8 ctrl 12h");
        set_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h05, 8'h06, 8'h10, 1'b0);
        tick1();
        expect_rd(4'h3, 16'h0032, "R8 11am to 12pm");
        expect_rd(4'h5, 16'h0005, "R8 noon no date step");
        set_time(8'h59, 8'h59, 8'h32, 8'h02, 8'h05, 8'h06, 8'h10, 1'b0);
        tick1();
        expect_rd(4'h3, 16'h0021, "R8 12pm to 1pm");
        set_time(8'h59, 8'h59, 8'h31, 8'h02, 8'h05, 8'h06, 8'h10, 1'b0);
        tick1();
        expect_rd(4'h3, 16'h0012, "R8 11pm to 12am");
        expect_rd(4'h5, 16'h0006, "R8 midnight date step");
        expect_rd(4'h4, 16'h0003, "R8 midnight wday");
        wr(4'h0, 16'h0001);

        // R5 tick coincident with load
        wr(4'h1, 16'h0030);
        wr(4'h8, 16'h8000);
        tick1();
        expect_rd(4'h1, 16'h0030, "R5 tick dropped");
        tick1();
        expect_rd(4'h1, 16'h0031, "R5 tick after load");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule